// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block produces the byte-address stream for one DMA channel whose transfer is laid out in three levels. The lowest level is an array of contiguous bytes. A frame is made of several arrays, and a block is made of several frames. A load pulse captures a full parameter set into the block. That set holds the two 32-bit start addresses and, for each side, a signed array stride and a signed frame stride. It also holds the three counts, a separate array count for later frames, a sync-mode bit, and a per-side FIFO addressing mode with its width code.

After the load, each sync event releases work. In array-synchronised mode an event releases one array. In frame-synchronised mode it releases one whole frame. The block emits one source/destination byte-address pair per clock. Each pair comes with strobes that mark the last beat of an array, of a frame and of the whole block. An event that arrives while beats are still being produced is not queued. Instead it raises a sticky missed-event flag. While the channel waits, the start addresses of the next array are visible on position outputs.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, `beat_valid`, `array_done`, `frame_done`, `block_done` and `missed_evt` are 0, and sync events produce no beats until the first `cfg_load`.
- R2: A `cfg_load` pulse captures all `cfg_*` inputs, arms the channel to wait for an event, and clears `missed_evt`. The `cfg_*` inputs have no effect at other times.
- R3: An event sampled while the channel waits produces its first beat on the next rising edge. The remaining beats follow on consecutive cycles with no gaps.
- R4: With `cfg_ab_sync`=0 (array-synchronised), each event yields exactly ACNT beats. In incrementing mode the byte address rises by one per beat inside an array.
- R5: With `cfg_ab_sync`=1 (frame-synchronised), each event yields one whole frame of ACNT×(arrays in the frame) beats, back to back.
- R6: Each new array inside a frame starts at the previous array start plus that side's sign-extended 16-bit array stride.
- R7: Each new frame starts at the previous frame start plus that side's sign-extended 16-bit frame stride.
- R8: The first frame has BCNT arrays. In array-synchronised mode, every later frame has `cfg_bcnt_rld` arrays. In frame-synchronised mode, every frame has BCNT arrays.
- R9: `array_done` is 1 exactly on the last beat of each array, `frame_done` on the last beat of each frame, and `block_done` on the last beat of the block.
- R10: After the block's last beat, further events yield no beats and leave `missed_evt` and the position outputs unchanged until the next `cfg_load`.
- R11: An event sampled while beats are being produced sets `missed_evt`, which stays 1 until the next `cfg_load`. The event adds no beats.
- R12: A side's FIFO bit set to 1 selects FIFO addressing with width code w (0..5 mean 8<<w bits; 6 and 7 act as 5). In that mode the low w address bits count modulo 2^w bytes from the array start, and the bits above are held. Zero strides with incrementing mode repeat the same array addresses.
- R13: While the channel waits for an event, `pos_src`/`pos_dst` hold the start addresses of the next array to be transferred. These are the configured start addresses right after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture parameters and arm the channel |
| cfg_src_addr | input | 32 | Source start byte address |
| cfg_dst_addr | input | 32 | Destination start byte address |
| cfg_src_bidx | input | 16 | Source signed array stride |
| cfg_src_cidx | input | 16 | Source signed frame stride |
| cfg_dst_bidx | input | 16 | Destination signed array stride |
| cfg_dst_cidx | input | 16 | Destination signed frame stride |
| cfg_acnt | input | 16 | Bytes per array |
| cfg_bcnt | input | 16 | Arrays in the first frame |
| cfg_ccnt | input | 16 | Frames per block |
| cfg_bcnt_rld | input | 16 | Arrays per later frame in array-synchronised mode |
| cfg_ab_sync | input | 1 | 0 array-synchronised, 1 frame-synchronised |
| cfg_src_fifo | input | 1 | Source FIFO addressing |
| cfg_src_fwid | input | 3 | Source FIFO width code |
| cfg_dst_fifo | input | 1 | Destination FIFO addressing |
| cfg_dst_fwid | input | 3 | Destination FIFO width code |
| sync_evt | input | 1 | Synchronisation event |
| beat_valid | output | 1 | A byte-address pair is presented |
| beat_src | output | 32 | Source byte address of the beat |
| beat_dst | output | 32 | Destination byte address of the beat |
| array_done | output | 1 | Last beat of an array |
| frame_done | output | 1 | Last beat of a frame |
| block_done | output | 1 | Last beat of the block |
| missed_evt | output | 1 | Sticky flag for an event lost during a transfer |
| pos_src | output | 32 | Next source array start |
| pos_dst | output | 32 | Next destination array start |

## Verification
A wrong byte index or base register shows up as a wrong `beat_src` or `beat_dst` on the very beat that uses it. A wrong array, frame or reload counter shows up later, as a strobe on the wrong beat, an extra or missing beat, or a stride applied at the wrong point. That becomes visible only at the end of the current array or frame. A wrong channel state shows within one cycle of the next event: a beat where none should appear, or a missing one. It can also show as `missed_evt` changing when it should not. The position outputs expose the stride arithmetic between events, before any beat is produced.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  localparam logic SYNC_ARRAY = 1'b0;
  localparam logic SYNC_FRAME = 1'b1;
  localparam int   FIFO_WCODE_MAX = 5;
endpackage

// File: rtl/dma3d_side.sv
module dma3d_side #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [SW-1:0] arr_stride,
  input  logic [SW-1:0] frm_stride,
  input  logic          fifo_in,
  input  logic [2:0]    wcode_in,
  input  logic          step_arr,
  input  logic          step_frm,
  input  logic [CW-1:0] byte_idx,
  output logic [AW-1:0] arr_base,
  output logic [AW-1:0] byte_addr,
  output logic          fifo_mode
);
  import dma3d_pkg::*;

  localparam int XW = AW - SW;

  logic [AW-1:0] arr_q, frm_q;
  logic [SW-1:0] astr_q, fstr_q;
  logic          fifo_q;
  logic [2:0]    wsel_q;
  logic [AW-1:0] astr_x, fstr_x, lin, wmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_q  <= '0;
      frm_q  <= '0;
      astr_q <= '0;
      fstr_q <= '0;
      fifo_q <= 1'b0;
      wsel_q <= '0;
    end else if (load) begin
      arr_q  <= start_addr;
      frm_q  <= start_addr;
      astr_q <= arr_stride;
      fstr_q <= frm_stride;
      fifo_q <= fifo_in;
      wsel_q <= (int'(wcode_in) > FIFO_WCODE_MAX) ? 3'(FIFO_WCODE_MAX) : wcode_in;
    end else if (step_frm) begin
      frm_q <= frm_q + fstr_x;
      arr_q <= frm_q + fstr_x;
    end else if (step_arr) begin
      arr_q <= arr_q + astr_x;
    end
  end

  always_comb begin
    astr_x    = {{XW{astr_q[SW-1]}}, astr_q};
    fstr_x    = {{XW{fstr_q[SW-1]}}, fstr_q};
    lin       = arr_q + {{(AW-CW){1'b0}}, byte_idx};
    wmask     = ({{(AW-1){1'b0}}, 1'b1} << wsel_q) - {{(AW-1){1'b0}}, 1'b1};
    byte_addr = fifo_q ? ((arr_q & ~wmask) | (lin & wmask)) : lin;
  end

  assign arr_base  = arr_q;
  assign fifo_mode = fifo_q;
endmodule

// File: rtl/dma3d_ctl.sv
module dma3d_ctl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] acnt,
  input  logic [CW-1:0] bcnt,
  input  logic [CW-1:0] ccnt,
  input  logic [CW-1:0] bcnt_rld,
  input  logic          ab_sync,
  input  logic          sync_evt,
  output logic          beat,
  output logic [CW-1:0] byte_idx,
  output logic          step_arr,
  output logic          step_frm,
  output logic          arr_end,
  output logic          frm_end,
  output logic          blk_end,
  output logic          missed,
  output logic          ab_mode
);
  import dma3d_pkg::*;

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  seq_state_t    state_q;
  logic [CW-1:0] acnt_q, bcnt_q, rld_q;
  logic [CW-1:0] a_idx_q, b_left_q, c_left_q;
  logic          ab_q, missed_q;
  logic          last_byte, last_arr, last_frm;

  always_comb begin
    beat      = (state_q == ST_RUN);
    last_byte = (a_idx_q == acnt_q - ONE);
    last_arr  = (b_left_q == ONE);
    last_frm  = (c_left_q == ONE);
    arr_end   = beat && last_byte;
    frm_end   = arr_end && last_arr;
    blk_end   = frm_end && last_frm;
    step_arr  = arr_end && !last_arr;
    step_frm  = frm_end && !last_frm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_EMPTY;
      acnt_q   <= ONE;
      bcnt_q   <= ONE;
      rld_q    <= ONE;
      ab_q     <= SYNC_ARRAY;
      a_idx_q  <= '0;
      b_left_q <= ONE;
      c_left_q <= ONE;
      missed_q <= 1'b0;
    end else if (load) begin
      state_q  <= ST_WAIT;
      acnt_q   <= acnt;
      bcnt_q   <= bcnt;
      rld_q    <= bcnt_rld;
      ab_q     <= ab_sync;
      a_idx_q  <= '0;
      b_left_q <= bcnt;
      c_left_q <= ccnt;
      missed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (sync_evt) state_q <= ST_RUN;
        ST_RUN: begin
          if (sync_evt) missed_q <= 1'b1;
          if (!last_byte) begin
            a_idx_q <= a_idx_q + ONE;
          end else begin
            a_idx_q <= '0;
            if (last_arr) begin
              if (last_frm) begin
                state_q <= ST_DONE;
              end else begin
                c_left_q <= c_left_q - ONE;
                b_left_q <= (ab_q == SYNC_FRAME) ? bcnt_q : rld_q;
                state_q  <= ST_WAIT;
              end
            end else begin
              b_left_q <= b_left_q - ONE;
              if (ab_q == SYNC_ARRAY) state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign byte_idx = a_idx_q;
  assign missed   = missed_q;
  assign ab_mode  = ab_q;
endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [SW-1:0] cfg_src_bidx,
  input  logic [SW-1:0] cfg_src_cidx,
  input  logic [SW-1:0] cfg_dst_bidx,
  input  logic [SW-1:0] cfg_dst_cidx,
  input  logic [CW-1:0] cfg_acnt,
  input  logic [CW-1:0] cfg_bcnt,
  input  logic [CW-1:0] cfg_ccnt,
  input  logic [CW-1:0] cfg_bcnt_rld,
  input  logic          cfg_ab_sync,
  input  logic          cfg_src_fifo,
  input  logic [2:0]    cfg_src_fwid,
  input  logic          cfg_dst_fifo,
  input  logic [2:0]    cfg_dst_fwid,
  input  logic          sync_evt,
  output logic          beat_valid,
  output logic [AW-1:0] beat_src,
  output logic [AW-1:0] beat_dst,
  output logic          array_done,
  output logic          frame_done,
  output logic          block_done,
  output logic          missed_evt,
  output logic [AW-1:0] pos_src,
  output logic [AW-1:0] pos_dst
);
  localparam int NSIDE = 2;

  logic          beat, step_arr, step_frm, arr_end, frm_end, blk_end;
  logic          ab_mode_w, src_fifo_w;
  logic [CW-1:0] byte_idx;

  logic [AW-1:0] side_start [NSIDE];
  logic [SW-1:0] side_astr  [NSIDE];
  logic [SW-1:0] side_fstr  [NSIDE];
  logic          side_fin   [NSIDE];
  logic [2:0]    side_wcode [NSIDE];
  logic [AW-1:0] side_base  [NSIDE];
  logic [AW-1:0] side_addr  [NSIDE];
  logic          side_fmode [NSIDE];

  assign side_start[0] = cfg_src_addr;
  assign side_start[1] = cfg_dst_addr;
  assign side_astr[0]  = cfg_src_bidx;
  assign side_astr[1]  = cfg_dst_bidx;
  assign side_fstr[0]  = cfg_src_cidx;
  assign side_fstr[1]  = cfg_dst_cidx;
  assign side_fin[0]   = cfg_src_fifo;
  assign side_fin[1]   = cfg_dst_fifo;
  assign side_wcode[0] = cfg_src_fwid;
  assign side_wcode[1] = cfg_dst_fwid;

  dma3d_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .load(cfg_load),
    .acnt(cfg_acnt), .bcnt(cfg_bcnt), .ccnt(cfg_ccnt), .bcnt_rld(cfg_bcnt_rld),
    .ab_sync(cfg_ab_sync), .sync_evt(sync_evt),
    .beat(beat), .byte_idx(byte_idx), .step_arr(step_arr), .step_frm(step_frm),
    .arr_end(arr_end), .frm_end(frm_end), .blk_end(blk_end),
    .missed(missed_evt), .ab_mode(ab_mode_w)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma3d_side #(.AW(AW), .SW(SW), .CW(CW)) u_side (
      .clk(clk), .rst(rst), .load(cfg_load),
      .start_addr(side_start[s]), .arr_stride(side_astr[s]), .frm_stride(side_fstr[s]),
      .fifo_in(side_fin[s]), .wcode_in(side_wcode[s]),
      .step_arr(step_arr), .step_frm(step_frm), .byte_idx(byte_idx),
      .arr_base(side_base[s]), .byte_addr(side_addr[s]), .fifo_mode(side_fmode[s])
    );
  end

  assign src_fifo_w = side_fmode[0];
  assign pos_src    = side_base[0];
  assign pos_dst    = side_base[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_src   <= '0;
      beat_dst   <= '0;
      array_done <= 1'b0;
      frame_done <= 1'b0;
      block_done <= 1'b0;
    end else begin
      beat_valid <= beat;
      beat_src   <= side_addr[0];
      beat_dst   <= side_addr[1];
      array_done <= arr_end;
      frame_done <= frm_end;
      block_done <= blk_end;
    end
  end
endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_load,
  input logic          beat_valid,
  input logic [AW-1:0] beat_src,
  input logic          array_done,
  input logic          frame_done,
  input logic          block_done,
  input logic          missed_evt,
  input logic          ab_mode,
  input logic          src_fifo
);
  // R9
  blk_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    block_done |-> (frame_done && array_done && beat_valid));

  // R9
  frm_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> array_done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    block_done |=> !beat_valid);

  // R4
  array_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (array_done && !ab_mode) |=> !beat_valid);

  // R4
  byte_step_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !array_done && !src_fifo && !$past(cfg_load))
      |=> (beat_valid && beat_src == $past(beat_src) + 1));

  // R11
  missed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (missed_evt && !cfg_load) |=> missed_evt);

  // R2
  missed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !missed_evt);
endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .beat_valid(beat_valid),
  .beat_src(beat_src), .array_done(array_done), .frame_done(frame_done),
  .block_done(block_done), .missed_evt(missed_evt), .ab_mode(ab_mode_w),
  .src_fifo(src_fifo_w)
);

// File: tb/dma3d_addr_seq_test.sv
`timescale 1ns/1ps
module dma3d_addr_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cfg_load = 1'b0, sync_evt = 1'b0;
  logic [31:0] c_src = '0, c_dst = '0;
  logic [15:0] c_sb = '0, c_sc = '0, c_db = '0, c_dc = '0;
  logic [15:0] c_a = 16'd1, c_b = 16'd1, c_c = 16'd1, c_r = 16'd1;
  logic        c_ab = 1'b0, c_sf = 1'b0, c_df = 1'b0;
  logic [2:0]  c_sw = '0, c_dw = '0;

  logic        beat_valid, array_done, frame_done, block_done, missed_evt;
  logic [31:0] beat_src, beat_dst, pos_src, pos_dst;

  int checks = 0, errors = 0;

  dma3d_addr_seq uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_src_addr(c_src), .cfg_dst_addr(c_dst),
    .cfg_src_bidx(c_sb), .cfg_src_cidx(c_sc), .cfg_dst_bidx(c_db), .cfg_dst_cidx(c_dc),
    .cfg_acnt(c_a), .cfg_bcnt(c_b), .cfg_ccnt(c_c), .cfg_bcnt_rld(c_r),
    .cfg_ab_sync(c_ab), .cfg_src_fifo(c_sf), .cfg_src_fwid(c_sw),
    .cfg_dst_fifo(c_df), .cfg_dst_fwid(c_dw), .sync_evt(sync_evt),
    .beat_valid(beat_valid), .beat_src(beat_src), .beat_dst(beat_dst),
    .array_done(array_done), .frame_done(frame_done), .block_done(block_done),
    .missed_evt(missed_evt), .pos_src(pos_src), .pos_dst(pos_dst)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] exp_addr(logic [31:0] base, int i, logic fifo, logic [2:0] w);
    int wc;
    logic [31:0] m;
    if (!fifo) return base + i;
    wc = (w > 3'd5) ? 5 : int'(w);
    m  = (32'd1 << wc) - 32'd1;
    return (base & ~m) | ((base + i) & m);
  endfunction

  task automatic do_load();
    @(negedge clk) cfg_load = 1'b1;
    @(negedge clk) cfg_load = 1'b0;
    chk("R13", "pos_src after load", pos_src, c_src);
    chk("R13", "pos_dst after load", pos_dst, c_dst);
    chk("R2", "missed after load", {31'd0, missed_evt}, 32'd0);
  endtask

  task automatic fire_evt();
    @(negedge clk) sync_evt = 1'b1;
    @(negedge clk) sync_evt = 1'b0;
    chk("R3", "no beat in event cycle", {31'd0, beat_valid}, 32'd0);
  endtask

  // Reference walk of a whole block, derived from R3..R9, R12, R13.
  task automatic run_block(string tag);
    logic [31:0] sa = c_src, sf = c_src, da = c_dst, df = c_dst;
    for (int f = 0; f < int'(c_c); f++) begin
      int narr = (f == 0 || c_ab) ? int'(c_b) : int'(c_r);
      for (int a = 0; a < narr; a++) begin
        bit la, lb;
        if (!c_ab || a == 0) fire_evt();
        for (int i = 0; i < int'(c_a); i++) begin
          bit li = (i == int'(c_a) - 1);
          @(negedge clk);
          la = li && (a == narr - 1);
          lb = la && (f == int'(c_c) - 1);
          chk(c_ab ? "R5" : "R3", {tag, " beat_valid"}, {31'd0, beat_valid}, 32'd1);
          chk("R6/R7/R12", {tag, " beat_src"}, beat_src, exp_addr(sa, i, c_sf, c_sw));
          chk("R6/R7/R12", {tag, " beat_dst"}, beat_dst, exp_addr(da, i, c_df, c_dw));
          chk("R9", {tag, " array_done"}, {31'd0, array_done}, {31'd0, li});
          chk("R9", {tag, " frame_done"}, {31'd0, frame_done}, {31'd0, la});
          chk("R9", {tag, " block_done"}, {31'd0, block_done}, {31'd0, lb});
        end
        if (!(a == narr - 1 && f == int'(c_c) - 1)) begin
          if (a == narr - 1) begin
            sf = sf + sx(c_sc); sa = sf;
            df = df + sx(c_dc); da = df;
          end else begin
            sa = sa + sx(c_sb);
            da = da + sx(c_db);
          end
          if (!c_ab) begin
            chk("R13", {tag, " pos_src between events"}, pos_src, sa);
            chk("R13", {tag, " pos_dst between events"}, pos_dst, da);
          end
        end
      end
    end
    @(negedge clk);
    chk("R10", {tag, " quiet after block"}, {31'd0, beat_valid}, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "beat_valid", {31'd0, beat_valid}, 32'd0);
    chk("R1", "strobes", {29'd0, array_done, frame_done, block_done}, 32'd0);
    chk("R1", "missed", {31'd0, missed_evt}, 32'd0);
    fire_evt();
    repeat (3) begin
      @(negedge clk);
      chk("R1", "no beat before load", {31'd0, beat_valid}, 32'd0);
    end
  endtask

  task automatic t_array_sync();
    // R4 R6 R7 R8: signed strides, later frames use reload count
    c_src = 32'h1000; c_sb = 16'h0010; c_sc = 16'h0100;
    c_dst = 32'h2000; c_db = 16'hFFFC; c_dc = 16'h0040;
    c_a = 16'd2; c_b = 16'd2; c_c = 16'd3; c_r = 16'd3;
    c_ab = 1'b0; c_sf = 1'b0; c_df = 1'b0;
    do_load();
    c_src = 32'hDEAD0000; c_a = 16'd9;  // R2: ignored without a load
    c_src = 32'h1000; c_a = 16'd2;
    run_block("R8 array-sync");
  endtask

  task automatic t_frame_sync();
    // R5 R8: every frame uses BCNT, reload value ignored
    c_src = 32'h0000_0000; c_sb = 16'd8; c_sc = 16'h0020;
    c_dst = 32'h0000_8000; c_db = 16'd3; c_dc = 16'hFFF0;
    c_a = 16'd3; c_b = 16'd2; c_c = 16'd2; c_r = 16'd5;
    c_ab = 1'b1;
    do_load();
    run_block("R5 frame-sync");
  endtask

  task automatic t_fixed();
    // R12: width code 0 is a fixed byte; zero strides repeat the array
    c_src = 32'h4000; c_sb = 0; c_sc = 0; c_sf = 1'b1; c_sw = 3'd0;
    c_dst = 32'h5000; c_db = 0; c_dc = 0; c_df = 1'b0;
    c_a = 16'd3; c_b = 16'd2; c_c = 16'd2; c_r = 16'd1; c_ab = 1'b0;
    do_load();
    run_block("R12 fixed");
  endtask

  task automatic t_fifo_wrap();
    // R12: 32-bit window on source, code 7 clamps to 256-bit on destination
    c_src = 32'h3002; c_sf = 1'b1; c_sw = 3'd2;
    c_dst = 32'h601E; c_df = 1'b1; c_dw = 3'd7;
    c_a = 16'd6; c_b = 16'd1; c_c = 16'd1; c_ab = 1'b0;
    do_load();
    run_block("R12 wrap");
    c_sf = 1'b0; c_df = 1'b0; c_sw = 0; c_dw = 0;
  endtask

  task automatic t_missed();
    // R11: event during an array is flagged, not queued
    c_src = 32'h7000; c_dst = 32'h7800; c_sb = 16'd4; c_db = 16'd4; c_sc = 0; c_dc = 0;
    c_a = 16'd4; c_b = 16'd2; c_c = 16'd1; c_ab = 1'b0;
    do_load();
    fire_evt();
    @(negedge clk) sync_evt = 1'b1;
    @(negedge clk) sync_evt = 1'b0;
    chk("R11", "missed set", {31'd0, missed_evt}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R11", "array still 4 beats", {30'd0, beat_valid, array_done}, 32'd3);
    repeat (3) begin
      @(negedge clk);
      chk("R11", "lost event adds no beats", {31'd0, beat_valid}, 32'd0);
      chk("R11", "missed sticky", {31'd0, missed_evt}, 32'd1);
    end
    chk("R13", "pos_src next array", pos_src, 32'h7004);
    do_load();
  endtask

  task automatic t_after_done();
    logic [31:0] ps, pd;
    c_src = 32'h9000; c_dst = 32'hA000; c_a = 16'd1; c_b = 16'd1; c_c = 16'd1;
    do_load();
    run_block("R10 short");
    ps = pos_src; pd = pos_dst;
    repeat (2) begin
      fire_evt();
      repeat (2) begin
        @(negedge clk);
        chk("R10", "event after block ignored", {31'd0, beat_valid}, 32'd0);
      end
    end
    chk("R10", "missed unchanged", {31'd0, missed_evt}, 32'd0);
    chk("R10", "pos_src unchanged", pos_src, ps);
    chk("R10", "pos_dst unchanged", pos_dst, pd);
  endtask

  initial begin
    t_reset();
    t_array_sync();
    t_frame_sync();
    t_fixed();
    t_fifo_wrap();
    t_missed();
    t_after_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule